// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block gives a host one 32-bit window word through which it reaches a 256-entry space of byte-wide internal registers. The host writes a single command word that packs an internal address, a byte to store and a direction bit. The bridge then runs the internal access over a fixed number of slow-domain ticks. A busy flag in the same word stays set for the whole access. When a read access finishes, the fetched byte is latched into the top byte of the window word. Software first issues the command, then polls until busy clears, and only then takes the read byte.

The slow domain is modelled as a clock-enable tick that divides the host clock by `DIV`. One access lasts `ACC_TICKS` ticks. The internal strobe fires on the host-clock cycle that carries the last tick of the access. Reading the window word returns the captured command fields, the busy flag and the latched read byte.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the window word reads all zero and neither internal strobe is asserted.
- R2: A command's bits [7:0] appear on `ia_addr` and its bits [15:8] on `ia_wdata` for the whole access, including the strobe cycle.
- R3: A command with bit 16 = 1 produces exactly one single-cycle `ia_wr` pulse and no `ia_rd` pulse, in the `DIV*ACC_TICKS`-th cycle after the accepting edge.
- R4: A command with bit 16 = 0 produces exactly one single-cycle `ia_rd` pulse in that same cycle, and the byte on `ia_rdata` during the pulse appears in window bits [31:24] from the next cycle on.
- R5: Window bit 23 (busy) is 1 from the cycle after a command is accepted, for exactly `DIV*ACC_TICKS` cycles, and then returns to 0.
- R6: A window write while busy is 1 is ignored: the busy timing, the strobed address and data, and the read-back command fields are those of the original command, and no extra access follows.
- R7: Window bits [31:24] change only when a read access completes; write accesses leave them unchanged.
- R8: Window bits [16:0] read back the last accepted command, and bits [22:17] read as 0.
- R9: `ia_wr` and `ia_rd` are never asserted together, and neither is asserted while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; the slow domain is a divided enable of it |
| rst_n | input | 1 | Active-low synchronous reset |
| win_wr | input | 1 | Host write strobe for the window word |
| win_wdata | input | 32 | Command word: [7:0] address, [15:8] write byte, [16] 1 = write / 0 = read |
| win_rdata | output | 32 | Status word: [31:24] last read byte, [23] busy, [16:0] last command |
| ia_addr | output | 8 | Internal register address |
| ia_wdata | output | 8 | Internal write byte |
| ia_wr | output | 1 | Internal write strobe, one cycle |
| ia_rd | output | 1 | Internal read strobe, one cycle |
| ia_rdata | input | 8 | Internal read byte, sampled during `ia_rd` |

## Verification
The bench runs write and read accesses at the address extremes 0x00 and 0xFF and at scattered middle addresses. The responder returns a byte that is a nibble-swap of the address XOR a constant, so a latch from the wrong address or the wrong cycle shows up as a wrong value. Writes placed between reads show whether the read byte is held (R7). A command injected mid-access with every field inverted, and with the reserved bits set, separates a bridge that ignores it from one that restarts, re-targets or queues it. For each access the bench counts the busy cycles and the strobe position cycle by cycle, so an access that ends one tick early or one tick late is caught.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
package ibr_pkg;

  typedef struct packed {
    logic       is_wr;
    logic [7:0] wdata;
    logic [7:0] addr;
  } ibr_cmd_t;

  // Command fields taken from the low 17 bits of the window word.
  function automatic ibr_cmd_t decode_cmd(input logic [16:0] w);
    ibr_cmd_t c;
    c.addr  = w[7:0];
    c.wdata = w[15:8];
    c.is_wr = w[16];
    return c;
  endfunction

  // Status word: read byte, busy, reserved zeros, echoed command.
  function automatic logic [31:0] pack_status(input logic [7:0] rd_byte,
                                              input logic busy,
                                              input ibr_cmd_t c);
    return {rd_byte, busy, 6'b0, c.is_wr, c.wdata, c.addr};
  endfunction

  // Host-clock cycles that one access occupies.
  function automatic int unsigned access_cycles(input int unsigned div,
                                                input int unsigned ticks);
    return div * ticks;
  endfunction

endpackage

// File: rtl/ibr_tick_gen.sv
`timescale 1ns/1ps
module ibr_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == LAST);

      // Slow-domain ticks are never back to back when dividing (R5 timing).
      assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/ibr_seq.sv
`timescale 1ns/1ps
module ibr_seq #(
  parameter int unsigned ACC_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic tick,
  input  logic is_wr,
  output logic last,
  output logic wr_stb,
  output logic rd_stb
);

  localparam int unsigned TW = $clog2(ACC_TICKS + 1);
  localparam logic [TW-1:0] FINAL = TW'(ACC_TICKS - 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    tcnt <= '0;
    else if (!busy) tcnt <= '0;
    else if (tick) tcnt <= (tcnt == FINAL) ? '0 : tcnt + 1'b1;
  end

  assign last   = busy && tick && (tcnt == FINAL);
  assign wr_stb = last && is_wr;
  assign rd_stb = last && !is_wr;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_stb, rd_stb}));

  assert_strobe_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb) |-> busy);

  // R3/R4: a strobe is a single-cycle pulse.
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));

endmodule

// File: rtl/ibr_cmd_reg.sv
`timescale 1ns/1ps
module ibr_cmd_reg
  import ibr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_wr,
  input  logic [31:0] win_wdata,
  input  logic        last,
  input  logic        rd_stb,
  input  logic [7:0]  rd_in,
  output logic        busy,
  output ibr_cmd_t    cmd,
  output logic [31:0] status
);

  logic       accept;
  logic [7:0] rd_byte;
  logic       unused_hi;

  assign unused_hi = ^win_wdata[31:17];
  assign accept    = win_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cmd     <= '0;
      rd_byte <= '0;
    end else begin
      if (accept) begin
        busy <= 1'b1;
        cmd  <= decode_cmd(win_wdata[16:0]);
      end else if (last) begin
        busy <= 1'b0;
      end
      if (rd_stb) rd_byte <= rd_in;
    end
  end

  assign status = pack_status(rd_byte, busy, cmd);

  assert_accept_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_last_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

  assert_busy_ignores_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(cmd)));

  assert_rd_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_byte));

endmodule

// File: rtl/ibr_bridge.sv
`timescale 1ns/1ps
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned DIV       = 4,
  parameter int unsigned ACC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_wr,
  input  logic [31:0] win_wdata,
  output logic [31:0] win_rdata,
  output logic [7:0]  ia_addr,
  output logic [7:0]  ia_wdata,
  output logic        ia_wr,
  output logic        ia_rd,
  input  logic [7:0]  ia_rdata
);

  logic     busy;
  logic     tick;
  logic     last;
  logic     wr_stb;
  logic     rd_stb;
  ibr_cmd_t cmd;

  ibr_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick)
  );

  ibr_seq #(.ACC_TICKS(ACC_TICKS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .tick  (tick),
    .is_wr (cmd.is_wr),
    .last  (last),
    .wr_stb(wr_stb),
    .rd_stb(rd_stb)
  );

  ibr_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_wr   (win_wr),
    .win_wdata(win_wdata),
    .last     (last),
    .rd_stb   (rd_stb),
    .rd_in    (ia_rdata),
    .busy     (busy),
    .cmd      (cmd),
    .status   (win_rdata)
  );

  assign ia_addr  = cmd.addr;
  assign ia_wdata = cmd.wdata;
  assign ia_wr    = wr_stb;
  assign ia_rd    = rd_stb;

  // R2: address and data are steady while the access runs.
  assert_fields_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(ia_addr) && $stable(ia_wdata)));

endmodule

// File: tb/tb_ibr_bridge.sv
`timescale 1ns/1ps
module tb_ibr_bridge;

  localparam int unsigned DIV       = 4;
  localparam int unsigned ACC_TICKS = 3;
  localparam int N = DIV * ACC_TICKS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        win_wr;
  logic [31:0] win_wdata;
  logic [31:0] win_rdata;
  logic [7:0]  ia_addr, ia_wdata, ia_rdata;
  logic        ia_wr, ia_rd;

  int  n_chk = 0;
  int  n_bad = 0;
  logic [7:0] last_rd = 8'h00;

  always #4 clk = ~clk;

  function automatic logic [7:0] resp(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction

  assign ia_rdata = resp(ia_addr);

  ibr_bridge #(.DIV(DIV), .ACC_TICKS(ACC_TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr), .win_wdata(win_wdata),
    .win_rdata(win_rdata), .ia_addr(ia_addr), .ia_wdata(ia_wdata),
    .ia_wr(ia_wr), .ia_rd(ia_rd), .ia_rdata(ia_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; win_wr = 1'b0; win_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 window after reset", win_rdata, 32'h0);
    check("R1 strobes after reset", {30'h0, ia_wr, ia_rd}, 32'h0);
  endtask

  // One access; optionally inject a conflicting command while busy (R6).
  task automatic t_access(input logic [7:0] a, input logic [7:0] d,
                          input bit wr, input bit inject);
    int strobes = 0;
    int s_cycle = 0;
    int bad_busy = 0;
    logic [7:0] s_addr = 8'h00;
    logic [7:0] s_data = 8'h00;
    bit kind_ok = 1'b1;
    string tag;
    tag = inject ? "R6" : (wr ? "R3" : "R4");
    @(negedge clk);
    win_wdata = {15'h0, wr, d, a};
    win_wr = 1'b1;
    @(negedge clk);
    win_wr = 1'b0;
    for (int k = 1; k <= N + 1; k++) begin
      if (win_rdata[23] !== (k <= N)) bad_busy++;
      if (ia_wr || ia_rd) begin
        strobes++;
        s_cycle = k;
        s_addr = ia_addr;
        s_data = ia_wdata;
        if (ia_wr !== wr || ia_rd !== !wr) kind_ok = 1'b0;
      end
      if (inject && k == 3) begin
        win_wdata = {15'h7FFF, ~wr, ~d, ~a};
        win_wr = 1'b1;
      end
      if (inject && k == 4) win_wr = 1'b0;
      if (k <= N) @(negedge clk);
    end
    if (!wr) last_rd = resp(a);
    check({"R5 busy window ", tag}, bad_busy, 0);
    check({tag, " strobe count"}, strobes, 1);
    check({tag, " strobe cycle"}, s_cycle, N);
    check({"R9 strobe kind ", tag}, {31'h0, kind_ok}, 32'h1);
    check({"R2 strobe address ", tag}, {24'h0, s_addr}, {24'h0, a});
    if (wr) check({"R2 strobe data ", tag}, {24'h0, s_data}, {24'h0, d});
    check({"R8 R7 status word ", tag}, win_rdata,
          {last_rd, 1'b0, 6'b0, wr, d, a});
  endtask

  // After an injected command no second access may start (R6).
  task automatic t_idle_after_inject();
    int act = 0;
    for (int k = 0; k < N + 4; k++) begin
      @(negedge clk);
      if (ia_wr || ia_rd || win_rdata[23]) act++;
    end
    check("R6 no queued access", act, 0);
  endtask

  initial begin
    t_reset();
    t_access(8'h3C, 8'h5A, 1'b1, 1'b0);  // R3, R7 (read byte still 0)
    t_access(8'h07, 8'h00, 1'b0, 1'b0);  // R4
    t_access(8'hFF, 8'h00, 1'b1, 1'b0);  // R7 read byte held across a write
    t_access(8'hFF, 8'hAA, 1'b0, 1'b0);  // R4 top address
    t_access(8'h00, 8'h11, 1'b0, 1'b0);  // R4 bottom address
    t_access(8'h10, 8'hC3, 1'b1, 1'b1);  // R6 write with injection
    t_idle_after_inject();
    t_access(8'h81, 8'h00, 1'b0, 1'b1);  // R6 read with injection
    t_idle_after_inject();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule